// File: doc/BRIEF.md
# Pipelined ADC Digital Error Correction

This block sits behind the analog stages of a nine-stage pipelined analog-to-digital converter. Each stage quantizes its input coarsely and hands over a 2-bit decision. The block turns these decisions into one 10-bit conversion result per clock.

Two stages settle in each clock period, so a single sample's decisions reach the block spread out over five cycles. A per-stage delay line removes this skew, so that the nine codes of one sample meet in the same cycle. An overlap-add with one bit shared between neighbouring stages then forms the result. The redundancy means that a comparator offset in any of the first eight stages, if smaller than a quarter of full scale, leaves the output code unchanged.

The result is registered and presented as straight offset binary. A valid flag marks the point where the pipeline has filled. A control input can release the data lines to high impedance, for example when another driver shares the bus during test.

Top module: `adc_ec_correct`

## Requirements
- R1: The block has nine 2-bit stage inputs, packed with stage k at bits [2k+1:2k]. For one sample, stage k's code is presented floor(k/2) clock edges after stage 0's code. A new code is accepted on every stage on every edge.
- R2: Stage 0's code for a sample is captured at edge e. The corrected word for that sample appears on the data outputs just after edge e+5. Each later edge yields the word of the next sample.
- R3: With c_k the code of stage k, the word equals the sum of c_k·2^(8−k) over stages 0 to 7, plus c_8.
- R4: On stages 0 to 7 the code 11 is treated as 10. On stage 8, all four codes 00 to 11 carry their plain value.
- R5: The result is held within 0 to 1023. The largest input pattern, code 11 on every stage, gives exactly 1023 with no wrap.
- R6: Output coding is straight offset binary. When the stage codes come from an ideal pipeline model, an input at fraction f of the span (0 ≤ f < 1) yields floor(1024·f). A full-scale input gives all ones.
- R7: Comparator offsets in stages 0 to 7 whose magnitude is below a quarter of full scale do not change the output word.
- R8: While the three-state input is 1, the ten data outputs are high impedance and the valid output is still driven. While it is 0, the data outputs carry the registered word.
- R9: A synchronous active-high reset clears every delay line and the output register. After reset the data word is 0 and valid is 0.
- R10: After reset is released, valid stays 0 for the first five edges, becomes 1 just after the sixth, and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stage_codes_i | input | 18 | Raw 2-bit decisions of the nine stages, stage k at bits [2k+1:2k] |
| hiz_i | input | 1 | 1 puts the data outputs in high impedance |
| data_o | output | 10 | Corrected conversion word, straight offset binary |
| valid_o | output | 1 | High once the pipeline holds only post-reset samples |

## Verification
The assertions assume that the stage codes are 2-bit values driven to known levels on every edge. They also assume that the last stage's code arrives with its sample at the skew given in R1, because the alignment check relies on that stage needing only one register. The stimulus always drives all nine fields, changes them only away from the clock edge, and builds the skew from a per-sample code table. The stage codes come from an integer model of the converter whose residues always stay inside the redundancy range, including the cases with offsets injected on both comparators of the first eight stages.

// File: rtl/adc_ec_pkg.sv
package adc_ec_pkg;

    localparam int unsigned CODE_W = 2;

    typedef logic [CODE_W-1:0] stage_code_t;

    localparam stage_code_t CODE_OVER = 2'b11;
    localparam stage_code_t CODE_TOP  = 2'b10;

    // A redundant stage can only legally decide 00, 01 or 10.
    function automatic stage_code_t fold_code(stage_code_t c);
        return (c == CODE_OVER) ? CODE_TOP : c;
    endfunction

endpackage

// File: rtl/adc_ec_skew_line.sv
module adc_ec_skew_line
    import adc_ec_pkg::*;
#(
    parameter int unsigned DEPTH = 1
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  stage_code_t code_i,
    output stage_code_t code_o
);

    stage_code_t line_d [DEPTH];
    stage_code_t line_q [DEPTH];

    always_comb begin
        line_d[0] = code_i;
        for (int i = 1; i < DEPTH; i++) begin
            line_d[i] = line_q[i-1];
        end
        if (rst_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                line_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        line_q <= line_d;
    end

    assign code_o = line_q[DEPTH-1];

endmodule

// File: rtl/adc_ec_align.sv
module adc_ec_align
    import adc_ec_pkg::*;
#(
    parameter int unsigned NUM_STAGES     = 9,
    parameter int unsigned STAGES_PER_CLK = 2
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic [NUM_STAGES*CODE_W-1:0]     raw_i,
    output logic [NUM_STAGES*CODE_W-1:0]     aligned_o
);

    localparam int unsigned SKEW_MAX = (NUM_STAGES - 1) / STAGES_PER_CLK;
    localparam int unsigned LAST_LSB = (NUM_STAGES - 1) * CODE_W;

    // Early stages wait longer so every code of one sample meets here.
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        localparam int unsigned DEPTH = SKEW_MAX + 1 - (k / STAGES_PER_CLK);
        adc_ec_skew_line #(
            .DEPTH (DEPTH)
        ) u_line (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .code_i (raw_i[k*CODE_W +: CODE_W]),
            .code_o (aligned_o[k*CODE_W +: CODE_W])
        );
    end

    AST_LAST_STAGE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> aligned_o[LAST_LSB +: CODE_W] == $past(raw_i[LAST_LSB +: CODE_W])) // R1
        else $error("last stage code not aligned after one cycle");

endmodule

// File: rtl/adc_ec_combine.sv
module adc_ec_combine
    import adc_ec_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 9
) (
    input  logic [NUM_STAGES*CODE_W-1:0] aligned_i,
    output logic [NUM_STAGES:0]          word_o
);

    localparam int unsigned OUT_W = NUM_STAGES + 1;
    localparam int unsigned SUM_W = OUT_W + 1;
    localparam logic [SUM_W-1:0] MAX_CODE = {1'b0, {OUT_W{1'b1}}};

    logic [SUM_W-1:0] sum_full;

    // Overlap-add: adjacent stages share one bit of weight.
    always_comb begin
        sum_full = '0;
        for (int k = 0; k < NUM_STAGES - 1; k++) begin
            sum_full = sum_full
                     + (SUM_W'(fold_code(aligned_i[k*CODE_W +: CODE_W])) << (NUM_STAGES - 1 - k));
        end
        sum_full = sum_full + SUM_W'(aligned_i[(NUM_STAGES-1)*CODE_W +: CODE_W]);
        word_o   = (sum_full > MAX_CODE) ? MAX_CODE[OUT_W-1:0] : sum_full[OUT_W-1:0];
    end

endmodule

// File: rtl/adc_ec_correct.sv
module adc_ec_correct
    import adc_ec_pkg::*;
#(
    parameter int unsigned NUM_STAGES     = 9,
    parameter int unsigned STAGES_PER_CLK = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic [NUM_STAGES*CODE_W-1:0] stage_codes_i,
    input  logic                         hiz_i,
    output logic [NUM_STAGES:0]          data_o,
    output logic                         valid_o
);

    localparam int unsigned OUT_W    = NUM_STAGES + 1;
    localparam int unsigned SKEW_MAX = (NUM_STAGES - 1) / STAGES_PER_CLK;
    localparam int unsigned LATENCY  = SKEW_MAX + 1;
    localparam int unsigned CNT_W    = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] FILL_DONE = CNT_W'(LATENCY);

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic [CNT_W-1:0] fill;
        logic             valid;
    } state_t;

    logic [NUM_STAGES*CODE_W-1:0] aligned_w;
    logic [OUT_W-1:0]             sum_w;
    state_t                       st_d;
    state_t                       st_q;

    adc_ec_align #(
        .NUM_STAGES     (NUM_STAGES),
        .STAGES_PER_CLK (STAGES_PER_CLK)
    ) u_align (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .raw_i     (stage_codes_i),
        .aligned_o (aligned_w)
    );

    adc_ec_combine #(
        .NUM_STAGES (NUM_STAGES)
    ) u_combine (
        .aligned_i (aligned_w),
        .word_o    (sum_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.word  = sum_w;
        st_d.fill  = (st_q.fill == FILL_DONE) ? st_q.fill : st_q.fill + 1'b1;
        st_d.valid = (st_q.fill == FILL_DONE);
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign data_o  = hiz_i ? {OUT_W{1'bz}} : st_q.word;
    assign valid_o = st_q.valid;

    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (st_q.word == '0 && !st_q.valid)) // R9
        else $error("output register not cleared by reset");

    AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.valid |=> st_q.valid) // R10
        else $error("valid dropped without reset");

    AST_VALID_AFTER_FILL: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_q.valid) |-> $past(st_q.fill) == FILL_DONE) // R10
        else $error("valid rose before pipeline filled");

    AST_WORD_TRACK: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> st_q.word == $past(sum_w)) // R2
        else $error("output register missed corrected word");

endmodule

// File: tb/adc_ec_correct_tb.sv
module adc_ec_correct_tb;

    localparam int NS  = 9;
    localparam int OW  = 10;
    localparam int LAT = 5;
    localparam longint ONE = 65536;
    localparam logic [OW-1:0] BENCH_PAT = 10'h2A5;

    logic            clk = 1'b0;
    logic            rst;
    logic [NS*2-1:0] codes;
    logic            hiz;
    logic            tb_drive;
    wire  [OW-1:0]   bus;
    logic            valid;

    always #4 clk = ~clk;

    assign bus = tb_drive ? BENCH_PAT : {OW{1'bz}};

    adc_ec_correct u_dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .stage_codes_i (codes),
        .hiz_i         (hiz),
        .data_o        (bus),
        .valid_o       (valid)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [1:0] cd [0:1023][0:NS-1];
    int         exp_w [0:1023];

    task automatic check(string req, int act, int expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Ideal 1.5-bit-per-stage pipeline in fixed point (ONE = full scale 1.0).
    task automatic model(int idx, int tval, bit offs);
        longint x, hi, lo, d;
        x = longint'(2 * tval + 1) * 64 - ONE;
        for (int k = 0; k < NS - 1; k++) begin
            hi = ONE / 4 + (offs ? longint'((k * 5) % 7 - 3) * (ONE / 16) : 0);
            lo = -ONE / 4 + (offs ? longint'((k * 3) % 7 - 3) * (ONE / 16) : 0);
            if (x > hi)      d = 1;
            else if (x < lo) d = -1;
            else             d = 0;
            cd[idx][k] = 2'(d + 1);
            x = 2 * x - d * ONE;
        end
        d = ((x + ONE) * 2) / ONE;
        if (d > 3) d = 3;
        cd[idx][NS-1] = 2'(d);
    endtask

    function automatic int ref_sum(int idx);
        int s = 0;
        for (int k = 0; k < NS - 1; k++) begin
            s += ((cd[idx][k] == 2'b11) ? 2 : int'(cd[idx][k])) << (NS - 1 - k);
        end
        s += int'(cd[idx][NS-1]);
        if (s > 1023) s = 1023;
        return s;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        codes = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R9 reset word", int'(bus), 0);
        check("R9 reset valid", int'(valid), 0);
        rst = 1'b0;
    endtask

    task automatic run_stream(int n, string req);
        do_reset();
        for (int cyc = 0; cyc < n + LAT; cyc++) begin
            for (int k = 0; k < NS; k++) begin
                int s = cyc - k / 2;
                codes[2*k +: 2] = (s >= 0 && s < n) ? cd[s][k] : 2'b00;
            end
            @(posedge clk);
            @(negedge clk);
            check("R10 valid timing", int'(valid), (cyc >= LAT) ? 1 : 0);
            if (cyc >= LAT) begin
                check(req, int'(bus), exp_w[cyc - LAT]);
            end
        end
    endtask

    initial begin
        int unsigned lf;
        rst      = 1'b1;
        codes    = '0;
        hiz      = 1'b0;
        tb_drive = 1'b0;

        // R1 R2 R3 R6: ideal sweep over every output code
        for (int t = 0; t < 1024; t++) begin
            model(t, t, 1'b0);
            exp_w[t] = t;
        end
        run_stream(1024, "R1/R2/R3/R6 ideal sweep");

        // R7: comparator offsets inside redundancy range
        for (int t = 0; t < 1024; t++) begin
            model(t, t, 1'b1);
            exp_w[t] = t;
        end
        run_stream(1024, "R7 offset sweep");

        // R4 R5: direct code patterns including illegal 11
        for (int k = 0; k < NS; k++) begin
            cd[0][k] = 2'b11;
            cd[1][k] = 2'b00;
            cd[2][k] = 2'b00;
        end
        cd[1][0] = 2'b11;
        exp_w[0] = 1023;
        exp_w[1] = 512;
        exp_w[2] = 0;
        lf = 32'h1234_5678;
        for (int i = 3; i < 300; i++) begin
            lf = lf * 32'd1103515245 + 32'd12345;
            for (int k = 0; k < NS; k++) cd[i][k] = lf[2*k +: 2];
            exp_w[i] = ref_sum(i);
        end
        run_stream(300, "R4/R5 direct codes");

        // R8: three-state control
        @(negedge clk);
        for (int k = 0; k < NS; k++) codes[2*k +: 2] = 2'b01;
        repeat (LAT + 2) @(posedge clk);
        @(negedge clk);
        check("R8 driven before hiz", int'(bus), 511);
        hiz      = 1'b1;
        tb_drive = 1'b1;
        #1;
        check("R8 released bus", int'(bus), int'(BENCH_PAT));
        check("R8 valid still driven", int'(valid), 1);
        @(negedge clk);
        tb_drive = 1'b0;
        hiz      = 1'b0;
        #1;
        check("R8 driven after hiz", int'(bus), 511);

        // R9: reset in the middle of valid operation
        do_reset();
        @(posedge clk);
        @(negedge clk);
        check("R10 valid low after mid reset", int'(valid), 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule